// File: doc/BRIEF.md
# Ternary-Weight Dot-Product Accumulator

This block produces one output value of a fully connected layer whose weights can only be -1, 0 or +1. Each accepted step carries eight signed fixed-point activations and eight weights packed at two bits each. Every lane decodes its weight code and passes on zero, the activation, or the activation negated. No multiplier is used. The eight lane results are registered once, reduced by a binary adder tree and added into a wide signed running sum.

A vector of length d arrives as d/8 steps framed by a `in_first` flag on its opening step and a `in_last` flag on its closing step. When the closing step has passed both pipeline stages, `out_valid` pulses for one cycle and `out_sum` holds the raw integer dot product. Scaling back to real numbers is left to the consumer.

A two-state controller tracks framing. `ST_IDLE` means no vector is open. `ST_OPEN` means a vector has started and has not closed. The transitions are as follows:
- open: `ST_IDLE` to `ST_OPEN` on an accepted step with first set and last clear.
- single: `ST_IDLE` to `ST_IDLE` on a step with first and last both set.
- close: `ST_OPEN` to `ST_IDLE` on an accepted step with last set.
- continue/restart: `ST_OPEN` to `ST_OPEN` on a step without last, with or without first.

Top module: `ternary_dot_acc`

## Requirements
- R1: Lane i takes activation `in_act[16*i+15:16*i]` (two's complement) and weight code `in_wcode[2*i+1:2*i]`. Code 2'b00 contributes 0, code 2'b01 contributes +x and code 2'b11 contributes -x. Negating -32768 gives +32768 exactly.
- R2: The reserved weight code 2'b10 contributes 0.
- R3: Each accepted step adds the sum of its eight lane contributions to the running sum. Steps of one vector accumulate across cycles.
- R4: A step with `in_first` set discards the previous sum, so its own lane sum becomes the new value.
- R5: A step with `in_last` accepted at clock edge k makes `out_valid` high for exactly the cycle after edge k+1. In that cycle `out_sum` equals the vector's complete sum.
- R6: While no step is being taken, the running sum shown on `out_sum` keeps its value.
- R7: In `ST_IDLE`, a step with `in_valid` high but `in_first` low is discarded and leaves `out_sum` unchanged.
- R8: The 32-bit running sum wraps modulo 2^32 in two's complement on overflow.
- R9: During reset `in_ready` is low. After reset `out_valid` is 0, `out_sum` is 0 and `in_ready` is high.
- R10: A step with both `in_first` and `in_last` is a complete one-step vector. A new vector may start on the cycle right after the previous one's last step.
- R11: A step with `in_first` during `ST_OPEN` restarts the sum and keeps the vector open unless `in_last` is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A step is offered |
| in_ready | output | 1 | Step can be taken (high outside reset) |
| in_first | input | 1 | Step opens a vector |
| in_last | input | 1 | Step closes a vector |
| in_act | input | 128 | Eight signed 16-bit activations, lane 0 in the low bits |
| in_wcode | input | 16 | Eight 2-bit ternary weight codes, lane 0 in the low bits |
| out_valid | output | 1 | One-cycle strobe: `out_sum` is a finished result |
| out_sum | output | 32 | Signed running sum / completed dot product |

## Verification
Two events can land on the same clock edge. The first is the close of one vector, where its last step reaches the accumulator and raises the result strobe. The second is the opening of the next vector, whose first step is taken into the lane register at that same edge. A step carrying first and last together also merges clear and close in one operation. The bench provokes both cases with back-to-back one-step vectors, and with a new vector that starts in the cycle right after a last step. A behavioural model checks that the strobe shows the old total while the next step's clear appears one cycle later.

// File: rtl/tdot_pkg.sv
package tdot_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_OPEN = 1'b1
    } tdot_state_e;

    localparam logic [1:0] WC_ZERO = 2'b00;
    localparam logic [1:0] WC_POS  = 2'b01;
    localparam logic [1:0] WC_RSV  = 2'b10;
    localparam logic [1:0] WC_NEG  = 2'b11;

endpackage

// File: rtl/tdot_lane.sv
module tdot_lane
    import tdot_pkg::*;
#(
    parameter int ACT_W = 16
) (
    input  logic [ACT_W-1:0] act,
    input  logic [1:0]       code,
    output logic [ACT_W:0]   contrib
);

    logic [ACT_W:0] act_ext;

    assign act_ext = {act[ACT_W-1], act};

    always_comb begin
        unique case (code)
            WC_POS:  contrib = act_ext;
            WC_NEG:  contrib = -act_ext;
            default: contrib = '0;
        endcase
    end

endmodule

// File: rtl/tdot_tree.sv
module tdot_tree #(
    parameter int LANES = 8,
    parameter int IN_W  = 17,
    parameter int OUT_W = 32
) (
    input  logic [LANES*IN_W-1:0] leaves,
    output logic [OUT_W-1:0]      total
);

    localparam int NODES = 2*LANES - 1;

    logic [OUT_W-1:0] node [NODES];

    for (genvar i = 0; i < LANES; i++) begin : g_leaf
        logic [IN_W-1:0] lf;
        assign lf = leaves[i*IN_W +: IN_W];
        assign node[LANES-1+i] = {{(OUT_W-IN_W){lf[IN_W-1]}}, lf};
    end

    for (genvar n = 0; n < LANES-1; n++) begin : g_add
        assign node[n] = node[2*n+1] + node[2*n+2];
    end

    assign total = node[0];

endmodule

// File: rtl/ternary_dot_acc.sv
module ternary_dot_acc
    import tdot_pkg::*;
#(
    parameter int LANES = 8,
    parameter int ACT_W = 16,
    parameter int ACC_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic                   in_first,
    input  logic                   in_last,
    input  logic [LANES*ACT_W-1:0] in_act,
    input  logic [2*LANES-1:0]     in_wcode,
    output logic                   out_valid,
    output logic [ACC_W-1:0]       out_sum
);

    localparam int LW = ACT_W + 1;

    tdot_state_e state_q, state_d;
    logic take;

    logic [LANES*LW-1:0] lane_flat;
    logic [LANES*LW-1:0] s1_lanes;
    logic                s1_vld, s1_first, s1_last;
    logic [ACC_W-1:0]    tree_sum;
    logic [ACC_W-1:0]    acc_q;

    assign in_ready = ~rst;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        tdot_lane #(.ACT_W(ACT_W)) u_lane (
            .act     (in_act[i*ACT_W +: ACT_W]),
            .code    (in_wcode[2*i +: 2]),
            .contrib (lane_flat[i*LW +: LW])
        );
    end

    // framing controller: next state and step acceptance
    always_comb begin
        take    = 1'b0;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid && in_first) begin
                    take = 1'b1;
                    if (!in_last) state_d = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (in_valid) begin
                    take = 1'b1;
                    if (in_last) state_d = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // stage 1: registered lane contributions
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld   <= 1'b0;
            s1_first <= 1'b0;
            s1_last  <= 1'b0;
            s1_lanes <= '0;
        end else begin
            s1_vld <= take;
            if (take) begin
                s1_first <= in_first;
                s1_last  <= in_last;
                s1_lanes <= lane_flat;
            end
        end
    end

    tdot_tree #(.LANES(LANES), .IN_W(LW), .OUT_W(ACC_W)) u_tree (
        .leaves (s1_lanes),
        .total  (tree_sum)
    );

    // stage 2: accumulator and result strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= s1_vld && s1_last;
            if (s1_vld) acc_q <= (s1_first ? '0 : acc_q) + tree_sum;
        end
    end

    assign out_sum = acc_q;

endmodule

// File: rtl/tdot_chk.sv
module tdot_chk
    import tdot_pkg::*;
#(
    parameter int LANES = 8,
    parameter int ACC_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_ready,
    input logic               in_first,
    input logic               in_last,
    input logic [2*LANES-1:0] in_wcode,
    input logic               out_valid,
    input logic [ACC_W-1:0]   out_sum,
    input tdot_state_e        state_q,
    input logic               s1_vld
);

    AST_READY_OUT_OF_RST: assert property (@(posedge clk) !rst |-> in_ready); // R9
    AST_RESET_CLEARS: assert property (@(posedge clk) $past(rst) |-> (!out_valid && out_sum == '0)); // R9
    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (rst) !s1_vld |=> $stable(out_sum)); // R6
    AST_STRAY_DROPPED: assert property (@(posedge clk) disable iff (rst) (in_valid && !in_first && state_q == ST_IDLE) |=> !s1_vld); // R7
    AST_FIRST_ZERO_RESTART: assert property (@(posedge clk) disable iff (rst) (in_valid && in_ready && in_first && in_wcode == '0) |=> ##1 (out_sum == '0)); // R4
    AST_RESERVED_IS_ZERO: assert property (@(posedge clk) disable iff (rst) (in_valid && in_first && in_wcode == {LANES{WC_RSV}}) |=> ##1 (out_sum == '0)); // R2
    AST_STROBE_FROM_LAST: assert property (@(posedge clk) disable iff (rst) out_valid |-> $past(in_valid && in_last, 2)); // R5

endmodule

bind ternary_dot_acc tdot_chk #(.LANES(LANES), .ACC_W(ACC_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_first  (in_first),
    .in_last   (in_last),
    .in_wcode  (in_wcode),
    .out_valid (out_valid),
    .out_sum   (out_sum),
    .state_q   (state_q),
    .s1_vld    (s1_vld)
);

// File: tb/test_ternary_dot_acc.sv
module test_ternary_dot_acc;

    localparam int LANES = 8;
    localparam int ACT_W = 16;
    localparam int ACC_W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_first = 1'b0;
    logic in_last = 1'b0;
    logic [LANES*ACT_W-1:0] in_act = '0;
    logic [2*LANES-1:0] in_wcode = '0;
    logic in_ready, out_valid;
    logic [ACC_W-1:0] out_sum;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    string req_tag = "R9";

    int a [LANES];
    logic [1:0] c [LANES];

    // reference model state
    bit started = 0;
    bit open_v = 0;
    bit p_vld = 0, p_first = 0, p_last = 0;
    logic [31:0] p_sum = '0;
    logic [31:0] m_acc = '0;
    bit m_ov = 0;

    ternary_dot_acc #(.LANES(LANES), .ACT_W(ACT_W), .ACC_W(ACC_W)) i_ternary_dot_acc (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_first(in_first), .in_last(in_last), .in_act(in_act),
        .in_wcode(in_wcode), .out_valid(out_valid), .out_sum(out_sum)
    );

    always #5 clk = ~clk;

    task automatic chk(bit ok, string what, longint act_v, longint exp_v);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req_tag, what, act_v, exp_v);
        end
    endtask

    function automatic logic [31:0] step_sum();
        longint s = 0;
        for (int i = 0; i < LANES; i++) begin
            int x;
            x = int'($signed(in_act[i*ACT_W +: ACT_W]));
            if (in_wcode[2*i +: 2] == 2'b01) s += x;
            else if (in_wcode[2*i +: 2] == 2'b11) s -= x;
        end
        return s[31:0];
    endfunction

    always @(posedge clk) begin
        started = 1;
        cycles++;
        if (rst) begin
            m_acc = '0; m_ov = 0; p_vld = 0; open_v = 0;
        end else begin
            if (p_vld) begin
                m_acc = (p_first ? 32'd0 : m_acc) + p_sum;
                m_ov = p_last;
            end else begin
                m_ov = 0;
            end
            p_vld = in_valid && (in_first || open_v);
            if (p_vld) begin
                p_first = in_first;
                p_last = in_last;
                p_sum = step_sum();
                open_v = !in_last;
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            chk(out_valid === m_ov, "out_valid", longint'(out_valid), longint'(m_ov));
            chk(out_sum === m_acc, "out_sum", longint'($signed(out_sum)), longint'($signed(m_acc)));
            chk(in_ready === !rst, "in_ready", longint'(in_ready), longint'(!rst));
        end
    end

    always @(posedge clk) begin
        if (cycles > 200000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic send(bit f, bit l);
        @(negedge clk);
        in_valid = 1'b1; in_first = f; in_last = l;
        for (int i = 0; i < LANES; i++) begin
            in_act[i*ACT_W +: ACT_W] = a[i][ACT_W-1:0];
            in_wcode[2*i +: 2] = c[i];
        end
        @(posedge clk);
    endtask

    task automatic pause(int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(posedge clk);
    endtask

    // after a last step: result visible after the second edge
    task automatic expect_result(logic [31:0] exp_v, string tag);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        req_tag = tag;
        chk(out_valid === 1'b1, "directed strobe", longint'(out_valid), 1);
        chk(out_sum === exp_v, "directed sum", longint'($signed(out_sum)), longint'($signed(exp_v)));
    endtask

    task automatic randomize_step();
        for (int i = 0; i < LANES; i++) begin
            a[i] = int'($urandom_range(0, 65535)) - 32768;
            c[i] = 2'($urandom_range(0, 3));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        req_tag = "R9";
        chk(in_ready === 1'b0, "ready in reset", longint'(in_ready), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid === 1'b0 && out_sum === '0, "reset outputs", longint'(out_sum), 0);

        // R1 R2: mixed codes including the -32768 negation and a reserved code
        req_tag = "R1";
        a = '{100, -200, 300, 400, 500, -32768, 700, 800};
        c = '{2'b01, 2'b11, 2'b00, 2'b01, 2'b11, 2'b11, 2'b10, 2'b01};
        send(1, 1);
        expect_result(32'd33768, "R1");

        req_tag = "R2";
        a = '{1, 2, 3, 4, 5, 6, 7, 8};
        c = '{default: 2'b10};
        send(1, 1);
        expect_result(32'd0, "R2");

        // R3: three steps of +1 weights on unit activations
        req_tag = "R3";
        a = '{default: 1};
        c = '{default: 2'b01};
        send(1, 0); send(0, 0); send(0, 1);
        expect_result(32'd24, "R3");

        // R6: gaps inside a vector
        req_tag = "R6";
        randomize_step(); send(1, 0); pause(3);
        randomize_step(); send(0, 0); pause(2);
        randomize_step(); send(0, 1); pause(4);

        // R7: stray steps while idle
        req_tag = "R7";
        for (int k = 0; k < 4; k++) begin randomize_step(); send(0, k[0]); end
        pause(3);

        // R4 R10: back-to-back one-step vectors, then a vector opening right after a close
        req_tag = "R10";
        for (int k = 0; k < 5; k++) begin randomize_step(); send(1, 1); end
        randomize_step(); send(1, 0);
        randomize_step(); send(0, 1);
        req_tag = "R4";
        randomize_step(); send(1, 0);
        randomize_step(); send(0, 1);
        pause(3);

        // R11: restart in the middle of an open vector
        req_tag = "R11";
        a = '{default: 1000};
        c = '{default: 2'b01};
        send(1, 0); send(0, 0);
        a = '{default: 3};
        send(1, 0); send(0, 1);
        expect_result(32'd48, "R11");

        // R8: 8192 steps of +32768 per lane reach exactly 2^31 and wrap
        req_tag = "R8";
        a = '{default: -32768};
        c = '{default: 2'b11};
        for (int k = 0; k < 8192; k++) send(k == 0, k == 8191);
        expect_result(32'h8000_0000, "R8");

        // R3 R5: random framing with random gaps
        req_tag = "R5";
        for (int v = 0; v < 60; v++) begin
            int len;
            len = $urandom_range(1, 6);
            for (int k = 0; k < len; k++) begin
                randomize_step();
                send(k == 0, k == len - 1);
                if ($urandom_range(0, 3) == 0) pause($urandom_range(1, 2));
            end
        end
        pause(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule